// File: doc/BRIEF.md
# Flash Bus Write Capture Front End

This block sits between the asynchronous pins of a byte-wide parallel flash model and its internal command logic. A fast internal clock samples the three active-low enables (chip, output, write), the 18-bit address and the 8-bit data bus. The enables pass through a synchronizer and a stability filter. A capture state machine then resolves which enable moved first. The address is taken when the later of chip enable and write enable falls. The data is taken when the first of them rises. At that second point a one-clock write strobe goes out with the captured pair.

On the read side the block decides when the data pins are driven. It drives them only when chip enable and output enable are low and write enable is high. The value driven comes from the downstream read multiplexer. A separate timer watches for bus inactivity and raises an automatic-standby flag after a set interval. A read that is in progress keeps driving while the flag is high.

The write strobe is a valid-only stream toward the command logic: `wr_valid` with `wr_addr` and `wr_data`. It has no ready input. A parallel bus host cannot be stalled, so the consumer must accept every strobe in the cycle it appears. Durations come from parameters given in nanoseconds and are converted using the sampling clock period (`CLK_NS`). The defaults are 10 ns per clock, a 5 ns glitch limit (a level must be seen in 2 consecutive samples) and a 150 ns standby timeout (15 quiet clocks).

Top module: `flash_bus_front`

## Requirements
- R1: The address reported with a write is the bus address present when the later of chip enable and write enable falls. More precisely, it is the value sampled one clock before the filter first sees that later falling level.
- R2: The data reported with a write is the bus data present when the first of chip enable and write enable rises. More precisely, it is the value sampled one clock before the filter first sees that rising level. Changes on the data bus after that rise have no effect.
- R3: No write strobe is produced if output enable is low when the write would begin, or if it falls at any time before the write ends.
- R4: While chip enable is high, write enable activity produces no strobe and `dq_oe` stays low.
- R5: While output enable is high, `dq_oe` is 0 and `dq_o` is 0.
- R6: A low level on chip enable or write enable seen in fewer than FILT_CYC consecutive samples (2 by default) is ignored and creates no write.
- R7: `auto_stby` rises after STBY_CYC consecutive clocks (15 by default) with no change on the filtered enables or the sampled address or data. Any such change clears it within 4 clocks.
- R8: Each valid write produces exactly one `wr_valid` pulse, one clock wide.
- R9: During a read (chip enable low, output enable low, write enable high) `dq_oe` is 1 and `dq_o` equals `rd_data_i`. This continues while `auto_stby` is high.
- R10: After reset `wr_valid`, `dq_oe` and `auto_stby` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| addr_i | input | 18 | Address pins |
| dq_i | input | 8 | Data bus as seen at the pins |
| rd_data_i | input | 8 | Read value from the downstream read multiplexer |
| dq_o | output | 8 | Value to drive onto the data pins |
| dq_oe | output | 1 | Drive enable for the data pins; 0 means high impedance |
| wr_valid | output | 1 | One-clock write strobe |
| wr_addr | output | 18 | Address captured for the current write |
| wr_data | output | 8 | Data captured for the current write |
| auto_stby | output | 1 | Automatic standby flag |

## Verification
A capture state machine stuck in the wrong state shows up at the ports in one of two ways. Either a write produces no strobe, or a strobe appears after a cycle in which output enable was low. Both become visible a few clocks after the enable rises, which is the synchronizer and filter latency. If the capture taps were taken at the wrong edge, the reported address or data would come from a value the bench places on the bus just before or after the intended edge. A wrong filter threshold lets a single-sample pulse become a strobe within about four clocks. A standby counter that fails to clear leaves `auto_stby` high after a bus change.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_WRITE = 2'd1,
    CAP_BLOCK = 2'd2
  } cap_state_e;

  // clock count that covers a duration given in nanoseconds
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/flash_fe_deglitch.sv
module flash_fe_deglitch #(
  parameter int FILT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic lvl_o
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(FILT_CYC - 1);

  logic s1_q, s2_q, lvl_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      s1_q <= pin_n;
      s2_q <= s1_q;
      if (s2_q == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LIM) begin
        lvl_q <= s2_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lvl_o = lvl_q;

  AST_FILT_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(s2_q) == lvl_q)); // R6

endmodule

// File: rtl/flash_fe_delay.sv
module flash_fe_delay #(
  parameter int W     = 26,
  parameter int DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] head_o,
  output logic [W-1:0] next_o,
  output logic [W-1:0] tap_o
);
  logic [W-1:0] pipe_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q[0] <= '0;
    else        pipe_q[0] <= din;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[i] <= '0;
      else        pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign head_o = pipe_q[0];
  assign next_o = pipe_q[1];
  assign tap_o  = pipe_q[DEPTH-1];

endmodule

// File: rtl/flash_fe_capture.sv
module flash_fe_capture
  import flash_fe_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_f,
  input  logic          oe_f,
  input  logic          we_f,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  cap_state_e st_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CAP_IDLE;
      addr_q <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      unique case (st_q)
        CAP_IDLE: begin
          if (!ce_f && !we_f) begin
            if (oe_f) begin
              st_q   <= CAP_WRITE;
              addr_q <= bus_addr;
            end else begin
              st_q <= CAP_BLOCK;
            end
          end
        end
        CAP_WRITE: begin
          if (!oe_f) begin
            st_q <= CAP_BLOCK;
          end else if (ce_f || we_f) begin
            vld_q  <= 1'b1;
            data_q <= bus_data;
            st_q   <= CAP_IDLE;
          end
        end
        CAP_BLOCK: begin
          if (ce_f || we_f) st_q <= CAP_IDLE;
        end
        default: st_q <= CAP_IDLE;
      endcase
    end
  end

  assign wr_valid = vld_q;
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R8
  AST_STROBE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(oe_f)); // R3

endmodule

// File: rtl/flash_fe_standby.sv
module flash_fe_standby #(
  parameter int STBY_CYC = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic activity,
  output logic stby_o
);
  localparam int SW = $clog2(STBY_CYC + 1);
  localparam logic [SW-1:0] TOP = SW'(STBY_CYC);

  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (activity)       cnt_q <= '0;
    else if (cnt_q != TOP)   cnt_q <= cnt_q + 1'b1;
  end

  assign stby_o = (cnt_q == TOP);

  AST_STBY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> !stby_o); // R7

endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
  import flash_fe_pkg::*;
#(
  parameter int AW        = 18,
  parameter int DW        = 8,
  parameter int CLK_NS    = 10,
  parameter int GLITCH_NS = 5,
  parameter int STBY_NS   = 150
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] dq_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          auto_stby
);
  localparam int FILT_CYC   = ns_to_cyc(GLITCH_NS, CLK_NS) + 1;
  localparam int STBY_CYC   = ns_to_cyc(STBY_NS, CLK_NS);
  localparam int PIPE_DEPTH = FILT_CYC + 3;
  localparam int BW         = AW + DW;

  // bit 0 chip enable, bit 1 output enable, bit 2 write enable
  logic [2:0] en_raw, en_f, en_prev_q;
  assign en_raw = {we_n, oe_n, ce_n};

  for (genvar i = 0; i < 3; i++) begin : g_en
    flash_fe_deglitch #(.FILT_CYC(FILT_CYC)) u_flt (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_n (en_raw[i]),
      .lvl_o (en_f[i])
    );
  end

  logic [BW-1:0] bus_head, bus_next, bus_tap;

  flash_fe_delay #(.W(BW), .DEPTH(PIPE_DEPTH)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    ({addr_i, dq_i}),
    .head_o (bus_head),
    .next_o (bus_next),
    .tap_o  (bus_tap)
  );

  flash_fe_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_f     (en_f[0]),
    .oe_f     (en_f[1]),
    .we_f     (en_f[2]),
    .bus_addr (bus_tap[BW-1:DW]),
    .bus_data (bus_tap[DW-1:0]),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_prev_q <= 3'b111;
    else        en_prev_q <= en_f;
  end

  logic bus_act;
  assign bus_act = (en_f != en_prev_q) || (bus_head != bus_next);

  flash_fe_standby #(.STBY_CYC(STBY_CYC)) u_stby (
    .clk      (clk),
    .rst_n    (rst_n),
    .activity (bus_act),
    .stby_o   (auto_stby)
  );

  assign dq_oe = !en_f[0] && !en_f[1] && en_f[2];
  assign dq_o  = dq_oe ? rd_data_i : '0;

  AST_NO_DRIVE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !dq_oe); // R5

endmodule

// File: tb/sim_flash_bus_front.sv
module sim_flash_bus_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [17:0] addr_i = '0;
  logic [7:0]  dq_i = '0, rd_data_i = '0;
  logic [7:0]  dq_o, wr_data;
  logic [17:0] wr_addr;
  logic dq_oe, wr_valid, auto_stby;

  int checks = 0, fails = 0, strobes = 0, doubles = 0;
  logic [17:0] last_addr = '0;
  logic [7:0]  last_data = '0;
  logic prev_vld = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_bus_front u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr_i(addr_i), .dq_i(dq_i), .rd_data_i(rd_data_i),
    .dq_o(dq_o), .dq_oe(dq_oe), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .auto_stby(auto_stby)
  );

  always @(negedge clk) begin
    if (wr_valid) begin
      strobes++;
      last_addr = wr_addr;
      last_data = wr_data;
      if (prev_vld) doubles++;
    end
    prev_vld = wr_valid;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    cyc(1);
    chk("R10 wr_valid", 32'(wr_valid), 0);
    chk("R10 dq_oe", 32'(dq_oe), 0);
    chk("R10 auto_stby", 32'(auto_stby), 0);
  endtask

  // chip enable first, write enable falls last and rises first
  task automatic t_we_ctrl;
    int s0 = strobes;
    addr_i = 18'h2A5C3; dq_i = 8'h5A; cyc(3);
    ce_n = 1'b0; cyc(4);
    we_n = 1'b0; cyc(6);
    we_n = 1'b1; cyc(6);
    ce_n = 1'b1; cyc(8);
    chk("R8 one strobe (WE ctrl)", 32'(strobes - s0), 1);
    chk("R1 addr (WE ctrl)", 32'(last_addr), 32'h2A5C3);
    chk("R2 data (WE ctrl)", 32'(last_data), 32'h5A);
  endtask

  // write enable first, chip enable falls last and rises first
  task automatic t_ce_ctrl;
    int s0 = strobes;
    addr_i = 18'h00111; dq_i = 8'h11; cyc(2);
    we_n = 1'b0; cyc(8);
    addr_i = 18'h3F00E; cyc(3);
    ce_n = 1'b0; cyc(3);
    addr_i = 18'h12345; cyc(3);
    dq_i = 8'hC7; cyc(2);
    ce_n = 1'b1; cyc(2);
    dq_i = 8'h99; cyc(6);
    we_n = 1'b1; cyc(8);
    chk("R8 one strobe (CE ctrl)", 32'(strobes - s0), 1);
    chk("R1 addr at later fall", 32'(last_addr), 32'h3F00E);
    chk("R2 data at first rise", 32'(last_data), 32'hC7);
    chk("R8 strobe one clock wide", 32'(doubles), 0);
  endtask

  task automatic t_oe_low;
    int s0 = strobes;
    oe_n = 1'b0; cyc(4);
    ce_n = 1'b0; we_n = 1'b0; cyc(6);
    we_n = 1'b1; ce_n = 1'b1; cyc(4);
    oe_n = 1'b1; cyc(6);
    chk("R3 no strobe with OE low at start", 32'(strobes - s0), 0);
    ce_n = 1'b0; cyc(3);
    we_n = 1'b0; cyc(6);
    oe_n = 1'b0; cyc(6);
    we_n = 1'b1; cyc(4);
    oe_n = 1'b1; ce_n = 1'b1; cyc(6);
    chk("R3 no strobe when OE falls mid write", 32'(strobes - s0), 0);
  endtask

  task automatic t_ce_high;
    int s0 = strobes;
    ce_n = 1'b1; oe_n = 1'b0; cyc(2);
    we_n = 1'b0; cyc(6);
    chk("R4 no drive with CE high", 32'(dq_oe), 0);
    we_n = 1'b1; cyc(4);
    oe_n = 1'b1; cyc(6);
    chk("R4 no strobe with CE high", 32'(strobes - s0), 0);
  endtask

  task automatic t_read;
    rd_data_i = 8'h3C;
    ce_n = 1'b0; oe_n = 1'b0; cyc(6);
    chk("R9 drive during read", 32'(dq_oe), 1);
    chk("R9 read data", 32'(dq_o), 32'h3C);
    oe_n = 1'b1; cyc(6);
    chk("R5 released with OE high", 32'(dq_oe), 0);
    chk("R5 zero value with OE high", 32'(dq_o), 0);
    ce_n = 1'b1; cyc(6);
  endtask

  task automatic t_glitch;
    int s0 = strobes;
    ce_n = 1'b0; cyc(4);
    we_n = 1'b0; cyc(1);
    we_n = 1'b1; cyc(8);
    ce_n = 1'b1; cyc(4);
    we_n = 1'b0; cyc(4);
    ce_n = 1'b0; cyc(1);
    ce_n = 1'b1; cyc(6);
    we_n = 1'b1; cyc(8);
    chk("R6 short pulses rejected", 32'(strobes - s0), 0);
  endtask

  task automatic t_standby;
    cyc(20);
    chk("R7 standby after quiet bus", 32'(auto_stby), 1);
    addr_i = 18'h0ABCD; cyc(4);
    chk("R7 standby cleared by activity", 32'(auto_stby), 0);
    rd_data_i = 8'h81;
    ce_n = 1'b0; oe_n = 1'b0; cyc(25);
    chk("R9 standby during read", 32'(auto_stby), 1);
    chk("R9 read keeps driving in standby", 32'(dq_oe), 1);
    rd_data_i = 8'hE4; #1;
    chk("R9 read data in standby", 32'(dq_o), 32'hE4);
    cyc(1);
    oe_n = 1'b1; ce_n = 1'b1; cyc(6);
  endtask

  initial begin
    cyc(5);
    rst_n = 1'b1;
    t_reset();
    t_we_ctrl();
    t_ce_ctrl();
    t_oe_low();
    t_ce_high();
    t_read();
    t_glitch();
    t_standby();
    chk("R8 no double strobe overall", 32'(doubles), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule